// File: doc/BRIEF.md
# I2C Slave Event Status Tracker

This block holds the status flags of an I2C slave controller and decides when SCL must be held low. A byte-level serial shifter reports single-cycle strobes to it. The strobes cover a data byte sent, a data byte received, an address phase with its match vector and direction, the end of the address ACK bit, a repeated START and a STOP. The flags show:

- whether the transmit holding register is loaded
- whether the receive holding register is full
- whether a byte transfer has finished
- the last acknowledge from the master
- the transfer direction
- one address-hit flag per slave address
- whether a repeated START has been seen
- whether the transfer is complete

Host logic loads the transmit side with a strobe. It clears the other flags with a vector of clear strobes. A configuration input gives the ACK value that the slave returns for received bytes; the block hands it to the shifter on `ack_out`. Optional clock stretching holds SCL from the end of the address ACK until software has cleared every address-hit flag.

Top module: `i2c_slave_evt_status`

## Requirements
- R1: While reset is asserted and just after it is released, every status output, `scl_hold` and `ack_out` are 0.
- R2: A `evt_byte_sent` strobe clears `st_tx_loaded`, sets `st_byte_done` and copies `mst_nak` into `st_nak`, all visible after the next clock edge. `sw_tx_load` sets `st_tx_loaded`, but a simultaneous `evt_byte_sent` wins.
- R3: A `evt_byte_rcvd` strobe sets `st_rx_full` and `st_byte_done` after the next edge. The same edge registers `cfg_ack_val` onto `ack_out`.
- R4: An address strobe whose hit vector, masked by `cfg_match_en`, is zero changes no flag. This covers an address meant for another slave, and one that matches but whose enable bit is clear.
- R5: An address strobe with a nonzero masked hit vector sets the matching `st_addr_hit` bits after the next edge. It also puts the block in the addressed state.
- R6: `st_dir_read` takes the `addr_read` value of an accepted address one cycle after the address-hit flag appears, which is two edges after the strobe.
- R7: If `cfg_stretch_en` and `cfg_stretch_on_am` are both 1 when an address is accepted, `scl_hold` rises after the following `evt_addr_ack` edge. It stays 1 until no `st_addr_hit` bit remains set. Without both bits, `scl_hold` stays 0.
- R8: `evt_rep_start` while addressed sets `st_rep_start` and leaves `st_xfer_cmp` unchanged. While idle it sets nothing.
- R9: `evt_stop` while addressed sets `st_xfer_cmp` and returns the block to idle. While idle it sets nothing.
- R10: `sw_clr` bit positions are: 0 receive full, 1 byte done, 2 NAK, 3 repeated start, 4 transfer complete, 5+i address hit i. A clear takes effect at the next edge, and a set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_byte_sent | input | 1 | Slave finished sending a data byte |
| evt_byte_rcvd | input | 1 | Slave finished receiving a data byte |
| mst_nak | input | 1 | Acknowledge bit from the master after a sent byte (1 = NAK) |
| evt_addr | input | 1 | Address phase finished |
| addr_hit_vec | input | NUM_ADDR | Which slave addresses matched (all zero: other slave) |
| addr_read | input | 1 | Direction of the address phase (1 = slave transmits) |
| evt_addr_ack | input | 1 | Address ACK bit has been driven |
| evt_rep_start | input | 1 | Repeated START seen on the bus |
| evt_stop | input | 1 | STOP seen on the bus |
| cfg_ack_val | input | 1 | ACK value to return for received bytes |
| cfg_match_en | input | NUM_ADDR | Enable for each slave address |
| cfg_stretch_en | input | 1 | Clock stretching allowed |
| cfg_stretch_on_am | input | 1 | Stretch after an address match |
| sw_tx_load | input | 1 | Host loaded the transmit holding register |
| sw_clr | input | NUM_ADDR+5 | Host flag clear strobes |
| st_tx_loaded | output | 1 | Transmit holding register loaded |
| st_rx_full | output | 1 | Receive holding register full |
| st_byte_done | output | 1 | Byte transfer finished |
| st_nak | output | 1 | Last master acknowledge was NAK |
| st_dir_read | output | 1 | Current direction (1 = slave transmits) |
| st_addr_hit | output | NUM_ADDR | Address-hit flags |
| st_rep_start | output | 1 | Repeated START seen while addressed |
| st_xfer_cmp | output | 1 | STOP seen while addressed |
| scl_hold | output | 1 | Request to hold SCL low |
| ack_out | output | 1 | ACK value handed to the shifter |

## Verification
The bench steps through the direction lag. A design that updates direction together with the hit flag shows the new direction one sample early. The stretch test releases the address-hit flags one at a time, so a design that lets SCL go on the first clear drops `scl_hold` too soon. Repeated START and STOP are sent both while addressed and while idle, so a design that ignores the addressed state sets flags it must leave alone. Same-cycle set and clear pairs catch a design that gives the clear priority.

// File: rtl/i2cs_evt_pkg.sv
package i2cs_evt_pkg;
   localparam int CLR_RX   = 0;
   localparam int CLR_BTF  = 1;
   localparam int CLR_NAK  = 2;
   localparam int CLR_REP  = 3;
   localparam int CLR_CMP  = 4;
   localparam int CLR_AM0  = 5;
   localparam int MAX_ADDR = 8;

   typedef enum logic {
      LINK_IDLE   = 1'b0,
      LINK_ACTIVE = 1'b1
   } link_state_t;
endpackage

// File: rtl/i2cs_flag_cell.sv
module i2cs_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/i2cs_addr_track.sv
module i2cs_addr_track
   import i2cs_evt_pkg::*;
#(
   parameter int NUM_ADDR = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                addr_evt_i,
   input  logic [NUM_ADDR-1:0] hit_vec_i,
   input  logic [NUM_ADDR-1:0] match_en_i,
   input  logic                addr_read_i,
   input  logic                rep_evt_i,
   input  logic                stop_evt_i,
   output logic [NUM_ADDR-1:0] am_set_o,
   output logic                hit_any_o,
   output logic                dir_o,
   output logic                active_o,
   output logic                rep_set_o,
   output logic                cmp_set_o
);
   link_state_t state_q;
   logic        pend_vld_q;
   logic        pend_dir_q;

   assign am_set_o  = addr_evt_i ? (hit_vec_i & match_en_i) : '0;
   assign hit_any_o = |am_set_o;
   assign active_o  = (state_q == LINK_ACTIVE);
   assign rep_set_o = rep_evt_i  && active_o;
   assign cmp_set_o = stop_evt_i && active_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LINK_IDLE;
      end else if (hit_any_o) begin
         state_q <= LINK_ACTIVE;
      end else if (stop_evt_i) begin
         state_q <= LINK_IDLE;
      end
   end

   // direction lags the hit flag by one cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vld_q <= 1'b0;
         pend_dir_q <= 1'b0;
         dir_o      <= 1'b0;
      end else begin
         pend_vld_q <= hit_any_o;
         if (hit_any_o)  pend_dir_q <= addr_read_i;
         if (pend_vld_q) dir_o      <= pend_dir_q;
      end
   end
endmodule

// File: rtl/i2cs_stretch_ctl.sv
module i2cs_stretch_ctl #(
   parameter int NUM_ADDR = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hit_any_i,
   input  logic                stretch_en_i,
   input  logic                stretch_on_am_i,
   input  logic                addr_ack_i,
   input  logic                stop_i,
   input  logic [NUM_ADDR-1:0] am_q_i,
   output logic                scl_hold_o
);
   logic armed_q;
   logic hold_q;
   logic am_any;

   assign am_any     = |am_q_i;
   assign scl_hold_o = hold_q && am_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (hit_any_i) begin
         armed_q <= stretch_en_i && stretch_on_am_i;
      end else if (addr_ack_i || stop_i) begin
         armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
      end else if (addr_ack_i && armed_q) begin
         hold_q <= 1'b1;
      end else if (!am_any) begin
         hold_q <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_slave_evt_status.sv
module i2c_slave_evt_status
   import i2cs_evt_pkg::*;
#(
   parameter int NUM_ADDR    = 2,
   parameter bit REG_ACK_OUT = 1'b1,
   localparam int CLR_W      = CLR_AM0 + NUM_ADDR
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt_byte_sent,
   input  logic                evt_byte_rcvd,
   input  logic                mst_nak,
   input  logic                evt_addr,
   input  logic [NUM_ADDR-1:0] addr_hit_vec,
   input  logic                addr_read,
   input  logic                evt_addr_ack,
   input  logic                evt_rep_start,
   input  logic                evt_stop,
   input  logic                cfg_ack_val,
   input  logic [NUM_ADDR-1:0] cfg_match_en,
   input  logic                cfg_stretch_en,
   input  logic                cfg_stretch_on_am,
   input  logic                sw_tx_load,
   input  logic [CLR_W-1:0]    sw_clr,
   output logic                st_tx_loaded,
   output logic                st_rx_full,
   output logic                st_byte_done,
   output logic                st_nak,
   output logic                st_dir_read,
   output logic [NUM_ADDR-1:0] st_addr_hit,
   output logic                st_rep_start,
   output logic                st_xfer_cmp,
   output logic                scl_hold,
   output logic                ack_out
);
   generate
      if (NUM_ADDR < 1 || NUM_ADDR > MAX_ADDR) begin : g_bad_num_addr
         $error("NUM_ADDR out of range");
      end
   endgenerate

   logic [NUM_ADDR-1:0] am_set;
   logic                hit_any;
   logic                link_active;
   logic                rep_set;
   logic                cmp_set;

   i2cs_addr_track #(.NUM_ADDR(NUM_ADDR)) i_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_evt_i  (evt_addr),
      .hit_vec_i   (addr_hit_vec),
      .match_en_i  (cfg_match_en),
      .addr_read_i (addr_read),
      .rep_evt_i   (evt_rep_start),
      .stop_evt_i  (evt_stop),
      .am_set_o    (am_set),
      .hit_any_o   (hit_any),
      .dir_o       (st_dir_read),
      .active_o    (link_active),
      .rep_set_o   (rep_set),
      .cmp_set_o   (cmp_set)
   );

   i2cs_flag_cell i_rx  (.clk(clk), .rst_n(rst_n), .set_i(evt_byte_rcvd),
                         .clr_i(sw_clr[CLR_RX]),  .q_o(st_rx_full));
   i2cs_flag_cell i_btf (.clk(clk), .rst_n(rst_n), .set_i(evt_byte_rcvd || evt_byte_sent),
                         .clr_i(sw_clr[CLR_BTF]), .q_o(st_byte_done));
   i2cs_flag_cell i_rep (.clk(clk), .rst_n(rst_n), .set_i(rep_set),
                         .clr_i(sw_clr[CLR_REP]), .q_o(st_rep_start));
   i2cs_flag_cell i_cmp (.clk(clk), .rst_n(rst_n), .set_i(cmp_set),
                         .clr_i(sw_clr[CLR_CMP]), .q_o(st_xfer_cmp));

   generate
      for (genvar gi = 0; gi < NUM_ADDR; gi++) begin : g_am
         i2cs_flag_cell i_am (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (am_set[gi]),
            .clr_i (sw_clr[CLR_AM0+gi]),
            .q_o   (st_addr_hit[gi])
         );
      end
   endgenerate

   // byte sent empties the holding register even against a host load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             st_tx_loaded <= 1'b0;
      else if (evt_byte_sent) st_tx_loaded <= 1'b0;
      else if (sw_tx_load)    st_tx_loaded <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                st_nak <= 1'b0;
      else if (evt_byte_sent)    st_nak <= mst_nak;
      else if (sw_clr[CLR_NAK])  st_nak <= 1'b0;
   end

   generate
      if (REG_ACK_OUT) begin : g_ack_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             ack_out <= 1'b0;
            else if (evt_byte_rcvd) ack_out <= cfg_ack_val;
         end
      end else begin : g_ack_comb
         assign ack_out = rst_n && cfg_ack_val;
      end
   endgenerate

   i2cs_stretch_ctl #(.NUM_ADDR(NUM_ADDR)) i_stretch (
      .clk             (clk),
      .rst_n           (rst_n),
      .hit_any_i       (hit_any),
      .stretch_en_i    (cfg_stretch_en),
      .stretch_on_am_i (cfg_stretch_on_am),
      .addr_ack_i      (evt_addr_ack),
      .stop_i          (evt_stop),
      .am_q_i          (st_addr_hit),
      .scl_hold_o      (scl_hold)
   );
endmodule

// File: rtl/i2cs_evt_checker.sv
module i2cs_evt_checker #(
   parameter int NUM_ADDR = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                evt_byte_sent,
   input logic                evt_byte_rcvd,
   input logic                evt_addr,
   input logic [NUM_ADDR-1:0] addr_hit_vec,
   input logic [NUM_ADDR-1:0] cfg_match_en,
   input logic                addr_read,
   input logic                evt_rep_start,
   input logic                evt_stop,
   input logic [NUM_ADDR+4:0] sw_clr,
   input logic                link_active,
   input logic                st_tx_loaded,
   input logic                st_rx_full,
   input logic                st_byte_done,
   input logic                st_dir_read,
   input logic [NUM_ADDR-1:0] st_addr_hit,
   input logic                st_rep_start,
   input logic                st_xfer_cmp,
   input logic                scl_hold
);
   // R2
   tx_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_byte_sent |=> (!st_tx_loaded && st_byte_done));

   // R3
   rx_got_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_byte_rcvd |=> (st_rx_full && st_byte_done));

   // R4
   ignore_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_addr && ((addr_hit_vec & cfg_match_en) == '0) && (sw_clr == '0))
      |=> $stable(st_addr_hit));

   // R6
   dir_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_addr && ((addr_hit_vec & cfg_match_en) != '0))
      |=> ##1 (st_dir_read == $past(addr_read, 2)));

   // R7
   hold_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_hold |-> (st_addr_hit != '0));

   // R8
   rep_keeps_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_rep_start && link_active && !evt_stop && !sw_clr[4])
      |=> (st_rep_start && $stable(st_xfer_cmp)));

   // R10
   set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_byte_rcvd && sw_clr[0]) |=> st_rx_full);
endmodule

bind i2c_slave_evt_status i2cs_evt_checker #(.NUM_ADDR(NUM_ADDR)) i_evt_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .evt_byte_sent (evt_byte_sent),
   .evt_byte_rcvd (evt_byte_rcvd),
   .evt_addr      (evt_addr),
   .addr_hit_vec  (addr_hit_vec),
   .cfg_match_en  (cfg_match_en),
   .addr_read     (addr_read),
   .evt_rep_start (evt_rep_start),
   .evt_stop      (evt_stop),
   .sw_clr        (sw_clr),
   .link_active   (link_active),
   .st_tx_loaded  (st_tx_loaded),
   .st_rx_full    (st_rx_full),
   .st_byte_done  (st_byte_done),
   .st_dir_read   (st_dir_read),
   .st_addr_hit   (st_addr_hit),
   .st_rep_start  (st_rep_start),
   .st_xfer_cmp   (st_xfer_cmp),
   .scl_hold      (scl_hold)
);

// File: tb/test_i2c_slave_evt_status.sv
module test_i2c_slave_evt_status;
   localparam int NA = 2;
   localparam int CW = NA + 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic evt_byte_sent = 0, evt_byte_rcvd = 0, mst_nak = 0, evt_addr = 0;
   logic [NA-1:0] addr_hit_vec = '0;
   logic addr_read = 0, evt_addr_ack = 0, evt_rep_start = 0, evt_stop = 0;
   logic cfg_ack_val = 0;
   logic [NA-1:0] cfg_match_en = '0;
   logic cfg_stretch_en = 0, cfg_stretch_on_am = 0, sw_tx_load = 0;
   logic [CW-1:0] sw_clr = '0;
   logic st_tx_loaded, st_rx_full, st_byte_done, st_nak, st_dir_read;
   logic [NA-1:0] st_addr_hit;
   logic st_rep_start, st_xfer_cmp, scl_hold, ack_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   i2c_slave_evt_status #(.NUM_ADDR(NA)) i_i2c_slave_evt_status (
      .clk(clk), .rst_n(rst_n), .evt_byte_sent(evt_byte_sent), .evt_byte_rcvd(evt_byte_rcvd),
      .mst_nak(mst_nak), .evt_addr(evt_addr), .addr_hit_vec(addr_hit_vec), .addr_read(addr_read),
      .evt_addr_ack(evt_addr_ack), .evt_rep_start(evt_rep_start), .evt_stop(evt_stop),
      .cfg_ack_val(cfg_ack_val), .cfg_match_en(cfg_match_en), .cfg_stretch_en(cfg_stretch_en),
      .cfg_stretch_on_am(cfg_stretch_on_am), .sw_tx_load(sw_tx_load), .sw_clr(sw_clr),
      .st_tx_loaded(st_tx_loaded), .st_rx_full(st_rx_full), .st_byte_done(st_byte_done),
      .st_nak(st_nak), .st_dir_read(st_dir_read), .st_addr_hit(st_addr_hit),
      .st_rep_start(st_rep_start), .st_xfer_cmp(st_xfer_cmp), .scl_hold(scl_hold),
      .ack_out(ack_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic quiet();
      evt_byte_sent = 0; evt_byte_rcvd = 0; evt_addr = 0; evt_addr_ack = 0;
      evt_rep_start = 0; evt_stop = 0; sw_tx_load = 0; sw_clr = '0;
   endtask

   task automatic clr(input logic [CW-1:0] v);
      sw_clr = v; step(); quiet();
   endtask

   task automatic t_reset();
      chk("R1 flags", {st_tx_loaded, st_rx_full, st_byte_done, st_nak, st_dir_read,
                       st_rep_start, st_xfer_cmp}, 0);
      chk("R1 hit/hold/ack", {st_addr_hit, scl_hold, ack_out}, 0);
   endtask

   task automatic t_rx();
      cfg_ack_val = 1; evt_byte_rcvd = 1; step(); quiet();
      chk("R3 rx_full", st_rx_full, 1);
      chk("R3 byte_done", st_byte_done, 1);
      chk("R3 ack_out", ack_out, 1);
      cfg_ack_val = 0; evt_byte_rcvd = 1; step(); quiet();
      chk("R3 ack_out low", ack_out, 0);
      clr(CW'(7'b0000011));
      chk("R10 clear rx/btf", {st_rx_full, st_byte_done}, 0);
   endtask

   task automatic t_tx();
      sw_tx_load = 1; step(); quiet();
      chk("R2 load", st_tx_loaded, 1);
      evt_byte_sent = 1; mst_nak = 1; step(); quiet();
      chk("R2 sent", {st_tx_loaded, st_byte_done, st_nak}, 3'b011);
      evt_byte_sent = 1; mst_nak = 0; step(); quiet();
      chk("R2 nak update", st_nak, 0);
      sw_tx_load = 1; evt_byte_sent = 1; step(); quiet();
      chk("R2 sent beats load", st_tx_loaded, 0);
      clr(CW'(7'b0000110));
      chk("R10 clear btf/nak", {st_byte_done, st_nak}, 0);
   endtask

   task automatic t_ignore();
      cfg_match_en = 2'b01;
      evt_addr = 1; addr_hit_vec = 2'b00; addr_read = 1; step(); quiet();
      chk("R4 other slave", st_addr_hit, 0);
      step();
      chk("R4 other slave dir", st_dir_read, 0);
      evt_addr = 1; addr_hit_vec = 2'b10; addr_read = 1; step(); quiet();
      chk("R4 disabled match", st_addr_hit, 0);
      step();
      chk("R4 disabled dir", {st_dir_read, scl_hold}, 0);
      evt_rep_start = 1; step(); quiet();
      chk("R8 idle rep ignored", st_rep_start, 0);
   endtask

   task automatic t_match_dir();
      cfg_match_en = 2'b11;
      evt_addr = 1; addr_hit_vec = 2'b10; addr_read = 1; step(); quiet();
      chk("R5 hit flag", st_addr_hit, 2'b10);
      chk("R6 dir not yet", st_dir_read, 0);
      step();
      chk("R6 dir updated", st_dir_read, 1);
      chk("R7 no stretch when off", scl_hold, 0);
      clr(CW'(7'b1000000));
      chk("R10 clear hit1", st_addr_hit, 0);
   endtask

   task automatic t_stretch();
      cfg_stretch_en = 1; cfg_stretch_on_am = 1;
      evt_addr = 1; addr_hit_vec = 2'b10; addr_read = 0; step(); quiet();
      evt_addr = 1; addr_hit_vec = 2'b01; step(); quiet();
      chk("R7 no hold before ack", scl_hold, 0);
      evt_addr_ack = 1; step(); quiet();
      chk("R7 hold after ack", scl_hold, 1);
      clr(CW'(7'b0100000));
      chk("R7 hold with one hit left", {st_addr_hit, scl_hold}, 3'b101);
      clr(CW'(7'b1000000));
      chk("R7 release", {st_addr_hit, scl_hold}, 0);
      cfg_stretch_on_am = 0;
      evt_addr = 1; addr_hit_vec = 2'b01; step(); quiet();
      evt_addr_ack = 1; step(); quiet();
      chk("R7 no hold without both bits", scl_hold, 0);
      clr(CW'(7'b0100000));
      cfg_stretch_en = 0;
   endtask

   task automatic t_rep_stop();
      clr(CW'(7'b0011000));
      evt_rep_start = 1; step(); quiet();
      chk("R8 rep set", st_rep_start, 1);
      chk("R8 cmp unchanged", st_xfer_cmp, 0);
      evt_stop = 1; step(); quiet();
      chk("R9 stop sets cmp", {st_xfer_cmp, st_rep_start}, 2'b11);
      clr(CW'(7'b0011000));
      evt_rep_start = 1; step(); quiet();
      chk("R9 idle after stop", st_rep_start, 0);
      evt_stop = 1; step(); quiet();
      chk("R9 idle stop ignored", st_xfer_cmp, 0);
   endtask

   task automatic t_priority();
      evt_byte_rcvd = 1; sw_clr = CW'(7'b0000011); step(); quiet();
      chk("R10 set beats clear", {st_rx_full, st_byte_done}, 2'b11);
      clr(CW'(7'b0000001));
      chk("R10 clear rx only", {st_rx_full, st_byte_done}, 2'b01);
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      t_reset();
      rst_n = 1;
      step();
      t_reset();
      t_rx();
      t_tx();
      t_ignore();
      t_match_dir();
      t_stretch();
      t_rep_stop();
      t_priority();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule